// File: doc/BRIEF.md
# Serial-Controlled Configuration Register Bank

This block is a two-wire serial target with a byte-wide register bank behind it. A controller addresses the target with a 7-bit device address followed by a direction bit. In a write, the first byte after the device address sets an internal sub-address pointer and every following byte is stored at the pointer, which then steps forward by one. In a read, the target returns bytes starting at the pointer as it was last set, stepping the pointer after each byte. This continues until the controller declines a byte or ends the transfer. One strap input picks between two device addresses, so two banks can share a bus.

The bank has two halves. Sub-addresses below 0x2C hold writable control bytes. Each of these comes out of reset at a fixed value, and all of them are presented together on a flat output bus for the rest of the chip. Sub-addresses 0x2C to 0x39 read back status bytes supplied from outside. A strap input chooses where an amplifier gain code and a source-select bit come from: either dedicated input pins or fields of the writable bank. Both serial lines are oversampled by the system clock. The data line is pulled low through an output enable and is never driven high.

Top module: `ctl_regbank_i2c`

## Requirements
- R1: The target acknowledges a device address of 7'b1000001 when `addr_sel` is 0 and 7'b1000011 when it is 1, with the direction bit following (0 write, 1 read). Any other address gets no acknowledge, and `sda_oe` stays 0 until the next START.
- R2: In a write, the byte after the device address loads the pointer. Each later byte is acknowledged and stored at the pointer, and the pointer then steps by one. Stored bytes appear on `rw_regs`, with sub-address n at bits [8n+7:8n]. Register contents change only while SCL is low.
- R3: A read returns bytes MSB first, starting at the pointer left by the last write or the last read, and steps the pointer after each byte.
- R4: An active-low reset sets sub-address 0x00 to 0x40, 0x02 to 0x81, 0x03 to 0x40, 0x04 to 0x08, 0x05 to 0xF3, 0x06 to 0xAD, 0x1E to 0x60, 0x1F to 0x91, 0x20 to 0x3D and 0x2A to 0x86. Every other writable byte resets to 0x00, and the pointer resets to 0x00.
- R5: Bytes written to sub-addresses 0x2C..0x39 are acknowledged but not stored. Reads there return `ro_data` byte k at sub-address 0x2C+k, taken from bits [8k+7:8k].
- R6: Reads at sub-addresses 0x3A and above return 0x00.
- R7: With `gain_mode` at 0, `gain_out` and `insel_out` follow `gain_pin` and `insel_pin`. With `gain_mode` at 1, they come from sub-address 0x1F bits [6:4] and sub-address 0x1E bit 0, and the pins have no effect.
- R8: When the controller does not acknowledge a read byte, the target releases SDA and sends no further bits.
- R9: A STOP returns the target to idle. A repeated START begins a fresh device address phase and keeps the pointer.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample both serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Device address strap |
| gain_mode | input | 1 | 0: gain and source select from pins, 1: from registers |
| gain_pin | input | 3 | Pin-supplied amplifier gain code |
| insel_pin | input | 1 | Pin-supplied source select |
| ro_data | input | 112 | Read-only status bytes for sub-addresses 0x2C..0x39 |
| rw_regs | output | 352 | Flat image of the writable bytes 0x00..0x2B |
| gain_out | output | 3 | Selected amplifier gain code |
| insel_out | output | 1 | Selected source select |

## Verification
Each serial line passes two synchronizer stages and an edge register, so the target's response to an SCL falling edge reaches `sda_oe` and `rw_regs` three to four system clocks after the edge. That response is an acknowledge, a new read bit, or a stored byte. The bench holds SCL low for ten clocks after every falling edge and samples SDA ten clocks into the high phase, so every acknowledge and read bit is due well before it is read. The gain mux is combinational, so `gain_out` and `insel_out` are due in the same cycle as a pin or mode change. The bench compares them and the whole of `rw_regs` against its model on every clock between transfers, when no write can be in flight.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_DEVACK,
      ST_SUBADR,
      ST_SUBACK,
      ST_WRBYTE,
      ST_WRACK,
      ST_RDBYTE,
      ST_RDACK
   } slv_state_t;

   // power-on value of each writable byte
   function automatic logic [7:0] reg_default(input int unsigned idx);
      case (idx)
         'h00:    return 8'h40;
         'h02:    return 8'h81;
         'h03:    return 8'h40;
         'h04:    return 8'h08;
         'h05:    return 8'hF3;
         'h06:    return 8'hAD;
         'h1E:    return 8'h60;
         'h1F:    return 8'h91;
         'h20:    return 8'h3D;
         'h2A:    return 8'h86;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ctl_regbank_sync.sv
module ctl_regbank_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic level,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ctl_regbank_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;

endmodule

// File: rtl/ctl_regbank_store.sv
module ctl_regbank_store
   import ctl_regbank_pkg::*;
#(
   parameter int NUM_RW = 44,
   parameter int NUM_RO = 14,
   parameter int SUB_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SUB_W-1:0]      wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [SUB_W-1:0]      rd_addr,
   input  logic [NUM_RO*8-1:0]   ro_data,
   output logic [7:0]            rd_data,
   output logic [NUM_RW*8-1:0]   rw_flat
);
   localparam int LAST_RO = NUM_RW + NUM_RO;

   generate
      for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
         localparam logic [7:0] DFLT = reg_default(i);
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= DFLT;
            else if (wr_en && (wr_addr == SUB_W'(i)))
               q <= wr_data;
         end
         assign rw_flat[i*8 +: 8] = q;
      end
   endgenerate

   // writes at or above NUM_RW match no byte above and are dropped
   always_comb begin
      rd_data = 8'h00;
      if (int'(rd_addr) < NUM_RW)
         rd_data = rw_flat[int'(rd_addr)*8 +: 8];
      else if (int'(rd_addr) < LAST_RO)
         rd_data = ro_data[(int'(rd_addr) - NUM_RW)*8 +: 8];
   end

endmodule

// File: rtl/ctl_regbank_slave.sv
module ctl_regbank_slave
   import ctl_regbank_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR0 = 7'h41,
   parameter logic [6:0] DEV_ADDR1 = 7'h43,
   parameter int         SUB_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_level,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_level,
   input  logic             sda_rise,
   input  logic             sda_fall,
   input  logic             addr_sel,
   input  logic [7:0]       rd_data,
   output logic             sda_oe,
   output logic [SUB_W-1:0] ptr,
   output logic             wr_en,
   output logic [7:0]       wr_data
);
   localparam logic [3:0] BYTE_BITS = 4'd8;

   slv_state_t  state;
   logic [3:0]  cnt;
   logic [7:0]  shreg;
   logic [7:0]  txreg;
   logic        rnw;
   logic        mack;
   logic [6:0]  my_addr;

   assign my_addr = addr_sel ? DEV_ADDR1 : DEV_ADDR0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         txreg   <= '0;
         rnw     <= 1'b0;
         mack    <= 1'b0;
         sda_oe  <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (scl_level && sda_fall) begin
            state  <= ST_DEVADR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (scl_level && sda_rise) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (scl_rise) begin
            case (state)
               ST_DEVADR, ST_SUBADR, ST_WRBYTE: begin
                  shreg <= {shreg[6:0], sda_level};
                  cnt   <= cnt + 4'd1;
               end
               ST_RDBYTE: cnt  <= cnt + 4'd1;
               ST_RDACK:  mack <= ~sda_level;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               ST_DEVADR: begin
                  if (cnt == BYTE_BITS) begin
                     if (shreg[7:1] == my_addr) begin
                        rnw    <= shreg[0];
                        sda_oe <= 1'b1;
                        state  <= ST_DEVACK;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               ST_DEVACK: begin
                  cnt <= '0;
                  if (rnw) begin
                     txreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                     state  <= ST_RDBYTE;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_SUBADR;
                  end
               end
               ST_SUBADR: begin
                  if (cnt == BYTE_BITS) begin
                     ptr    <= SUB_W'(shreg);
                     sda_oe <= 1'b1;
                     state  <= ST_SUBACK;
                  end
               end
               ST_SUBACK: begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  state  <= ST_WRBYTE;
               end
               ST_WRBYTE: begin
                  if (cnt == BYTE_BITS) begin
                     wr_en   <= 1'b1;
                     wr_data <= shreg;
                     sda_oe  <= 1'b1;
                     state   <= ST_WRACK;
                  end
               end
               ST_WRACK: begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  ptr    <= ptr + 1'b1;
                  state  <= ST_WRBYTE;
               end
               ST_RDBYTE: begin
                  if (cnt == BYTE_BITS) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RDACK;
                  end else begin
                     sda_oe <= ~txreg[3'(4'd7 - cnt)];
                  end
               end
               ST_RDACK: begin
                  if (mack) begin
                     cnt    <= '0;
                     txreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                     state  <= ST_RDBYTE;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/ctl_regbank_select.sv
module ctl_regbank_select #(
   parameter int NUM_RW    = 44,
   parameter int GAIN_REG  = 'h1F,
   parameter int GAIN_LSB  = 4,
   parameter int GAIN_W    = 3,
   parameter int INSEL_REG = 'h1E,
   parameter int INSEL_BIT = 0
) (
   input  logic                  gain_mode,
   input  logic [GAIN_W-1:0]     gain_pin,
   input  logic                  insel_pin,
   input  logic [NUM_RW*8-1:0]   rw_flat,
   output logic [GAIN_W-1:0]     gain_out,
   output logic                  insel_out
);
   localparam int GAIN_POS  = GAIN_REG * 8 + GAIN_LSB;
   localparam int INSEL_POS = INSEL_REG * 8 + INSEL_BIT;

   generate
      if (GAIN_LSB + GAIN_W > 8) begin : g_bad_gain
         $error("ctl_regbank_select: gain field leaves its byte");
      end
   endgenerate

   assign gain_out  = gain_mode ? rw_flat[GAIN_POS +: GAIN_W] : gain_pin;
   assign insel_out = gain_mode ? rw_flat[INSEL_POS]          : insel_pin;

endmodule

// File: rtl/ctl_regbank_i2c.sv
module ctl_regbank_i2c #(
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_RW      = 44,
   parameter int         NUM_RO      = 14,
   parameter logic [6:0] DEV_ADDR0   = 7'h41,
   parameter logic [6:0] DEV_ADDR1   = 7'h43,
   parameter int         GAIN_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_oe,
   input  logic                  addr_sel,
   input  logic                  gain_mode,
   input  logic [GAIN_W-1:0]     gain_pin,
   input  logic                  insel_pin,
   input  logic [NUM_RO*8-1:0]   ro_data,
   output logic [NUM_RW*8-1:0]   rw_regs,
   output logic [GAIN_W-1:0]     gain_out,
   output logic                  insel_out
);
   localparam int SUB_W = 8;

   generate
      if (NUM_RW + NUM_RO > (1 << SUB_W)) begin : g_bad_map
         $error("ctl_regbank_i2c: map exceeds the sub-address space");
      end
      if (NUM_RW <= 'h1F) begin : g_bad_rw
         $error("ctl_regbank_i2c: writable half must hold the gain byte");
      end
   endgenerate

   logic scl_level, scl_rise, scl_fall;
   logic sda_level, sda_rise, sda_fall;
   logic [SUB_W-1:0] ptr;
   logic             wr_en;
   logic [7:0]       wr_data;
   logic [7:0]       rd_data;

   ctl_regbank_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_in(scl_in),
      .level(scl_level), .rise(scl_rise), .fall(scl_fall)
   );

   ctl_regbank_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_in(sda_in),
      .level(sda_level), .rise(sda_rise), .fall(sda_fall)
   );

   ctl_regbank_slave #(
      .DEV_ADDR0(DEV_ADDR0), .DEV_ADDR1(DEV_ADDR1), .SUB_W(SUB_W)
   ) u_slave (
      .clk(clk), .rst_n(rst_n),
      .scl_level(scl_level), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_level(sda_level), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .addr_sel(addr_sel), .rd_data(rd_data), .sda_oe(sda_oe),
      .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data)
   );

   ctl_regbank_store #(
      .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .SUB_W(SUB_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
      .wr_data(wr_data), .rd_addr(ptr), .ro_data(ro_data),
      .rd_data(rd_data), .rw_flat(rw_regs)
   );

   ctl_regbank_select #(
      .NUM_RW(NUM_RW), .GAIN_W(GAIN_W)
   ) u_select (
      .gain_mode(gain_mode), .gain_pin(gain_pin), .insel_pin(insel_pin),
      .rw_flat(rw_regs), .gain_out(gain_out), .insel_out(insel_out)
   );

endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
   import ctl_regbank_pkg::*;
#(
   parameter int NUM_RW = 44,
   parameter int GAIN_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_in,
   input logic                sda_oe,
   input logic                gain_mode,
   input logic [GAIN_W-1:0]   gain_pin,
   input logic                insel_pin,
   input logic [NUM_RW*8-1:0] rw_regs,
   input logic [GAIN_W-1:0]   gain_out,
   input logic                insel_out
);
   logic [NUM_RW*8-1:0] dflt_image;

   generate
      for (genvar i = 0; i < NUM_RW; i++) begin : g_img
         assign dflt_image[i*8 +: 8] = reg_default(i);
      end
   endgenerate

   // R4: first cycle out of reset shows the default image
   assert_reset_image_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> rw_regs == dflt_image);

   // R2: stored bytes only move while the clock line is low
   assert_write_on_low_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rw_regs) |-> !scl_in);

   // R10: data line drive only changes while the clock line is low
   assert_oe_on_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_in);

   // R7: in register mode the pins cannot move the outputs
   assert_pins_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gain_mode && $past(gain_mode) && $stable(rw_regs)
         |-> $stable(gain_out) && $stable(insel_out));

endmodule

bind ctl_regbank_i2c ctl_regbank_chk #(.NUM_RW(NUM_RW), .GAIN_W(GAIN_W)) u_chk (.*);

// File: tb/test_ctl_regbank_i2c.sv
module test_ctl_regbank_i2c;
   localparam int NRW = 44;
   localparam int NRO = 14;
   localparam int Q   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_oe;
   logic addr_sel = 1'b0;
   logic gain_mode = 1'b0;
   logic [2:0] gain_pin = 3'b110;
   logic insel_pin = 1'b1;
   logic [NRO*8-1:0] ro_data;
   logic [NRW*8-1:0] rw_regs;
   logic [2:0] gain_out;
   logic insel_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic cmp_en = 1'b0;
   logic [7:0] mreg [NRW];
   logic [7:0] mptr = 8'h00;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   for (genvar k = 0; k < NRO; k++) begin : g_ro
      assign ro_data[k*8 +: 8] = 8'hC0 + 8'(k);
   end

   ctl_regbank_i2c i_ctl_regbank_i2c (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .gain_mode(gain_mode),
      .gain_pin(gain_pin), .insel_pin(insel_pin), .ro_data(ro_data),
      .rw_regs(rw_regs), .gain_out(gain_out), .insel_out(insel_out)
   );

   function automatic logic [7:0] dflt(int i);
      case (i)
         'h00: return 8'h40;  'h02: return 8'h81;  'h03: return 8'h40;
         'h04: return 8'h08;  'h05: return 8'hF3;  'h06: return 8'hAD;
         'h1E: return 8'h60;  'h1F: return 8'h91;  'h20: return 8'h3D;
         'h2A: return 8'h86;  default: return 8'h00;
      endcase
   endfunction

   function automatic logic [NRW*8-1:0] model_flat();
      logic [NRW*8-1:0] f;
      for (int i = 0; i < NRW; i++) f[i*8 +: 8] = mreg[i];
      return f;
   endfunction

   function automatic logic [7:0] model_read(logic [7:0] p);
      if (int'(p) < NRW) return mreg[p];
      if (int'(p) < NRW + NRO) return 8'hC0 + (p - 8'(NRW));
      return 8'h00;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NRW; i++) mreg[i] = dflt(i);
      mptr = 8'h00;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison between transfers (R2 R4 R5 R7)
   always @(negedge clk) begin
      cycles++;
      if (cmp_en) begin
         checks++;
         if (rw_regs !== model_flat()) begin
            errors++;
            $display("FAIL R2 register image actual=%0h expected=%0h", rw_regs, model_flat());
         end
         checks++;
         if ({gain_out, insel_out} !== (gain_mode ? {mreg['h1F][6:4], mreg['h1E][0]}
                                                  : {gain_pin, insel_pin})) begin
            errors++;
            $display("FAIL R7 mux actual=%0h expected=%0h", {gain_out, insel_out},
                     gain_mode ? {mreg['h1F][6:4], mreg['h1E][0]} : {gain_pin, insel_pin});
         end
      end
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=finish", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wq(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      cmp_en = 1'b0;
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(Q * 2);
      cmp_en = 1'b1;
   endtask

   task automatic wr_byte(logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(Q);
         scl_m = 1'b1; wq(2 * Q);
         scl_m = 1'b0;
      end
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      ack = ~sda_line; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic rd_byte(logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q);
         scl_m = 1'b1; wq(Q);
         b[i] = sda_line; wq(Q);
         scl_m = 1'b0;
      end
      sda_m = ~give_ack; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic put(string req, logic [7:0] b, logic exp_ack);
      logic a;
      wr_byte(b, a);
      chk(req, a, exp_ack);
   endtask

   task automatic put_data(logic [7:0] b);
      put("R2 data ack", b, 1'b1);
      if (int'(mptr) < NRW) mreg[mptr] = b;
      mptr++;
   endtask

   task automatic get(string req, logic give_ack);
      logic [7:0] b;
      rd_byte(give_ack, b);
      chk(req, b, model_read(mptr));
      mptr++;
   endtask

   initial begin
      model_reset();
      wq(5);
      rst_n = 1'b1;
      wq(3);
      chk("R4 reset image", (rw_regs === model_flat()), 1);
      chk("R7 pin mode after reset", {gain_out, insel_out}, {3'b110, 1'b1});
      chk("R10 idle release", sda_oe, 0);
      cmp_en = 1'b1;

      // R1 R2: write three bytes from 0x10
      i2c_start();
      put("R1 address 0x41 write", 8'h82, 1'b1);
      put("R2 sub ack", 8'h10, 1'b1); mptr = 8'h10;
      put_data(8'hA5); put_data(8'h5A); put_data(8'h33);
      i2c_stop();
      chk("R2 byte 0x11", rw_regs['h11*8 +: 8], 8'h5A);

      // R3 R9: set pointer, repeated start, read back
      i2c_start();
      put("R1 address", 8'h82, 1'b1);
      put("R2 sub ack", 8'h10, 1'b1); mptr = 8'h10;
      i2c_start();
      put("R9 repeated start read address", 8'h83, 1'b1);
      get("R3 read 0x10", 1'b1);
      get("R3 read 0x11", 1'b1);
      get("R3 read 0x12", 1'b0);
      chk("R8 released after nack", sda_oe, 0);
      i2c_stop();

      // R1: other address ignored
      i2c_start();
      put("R1 foreign address no ack", 8'h86, 1'b0);
      chk("R1 no drive", sda_oe, 0);
      i2c_stop();

      // R1 R7: alternate address, gain and source fields
      addr_sel = 1'b1;
      wq(4);
      i2c_start();
      put("R1 address 0x43 write", 8'h86, 1'b1);
      put("R2 sub ack", 8'h1E, 1'b1); mptr = 8'h1E;
      put_data(8'h01); put_data(8'h50);
      i2c_stop();
      gain_mode = 1'b1; wq(2);
      chk("R7 register gain", gain_out, 3'd5);
      chk("R7 register insel", insel_out, 1'b1);
      gain_pin = 3'b011; insel_pin = 1'b0; wq(2);
      chk("R7 pins ignored", {gain_out, insel_out}, {3'd5, 1'b1});
      gain_mode = 1'b0; wq(2);
      chk("R7 pins selected", {gain_out, insel_out}, {3'b011, 1'b0});

      // R5: write across the writable boundary
      i2c_start();
      put("R1 address", 8'h86, 1'b1);
      put("R2 sub ack", 8'h2A, 1'b1); mptr = 8'h2A;
      put_data(8'h11); put_data(8'h22);
      put("R5 read-only write ack", 8'h33, 1'b1); mptr++;
      put("R5 read-only write ack", 8'h44, 1'b1); mptr++;
      i2c_stop();
      chk("R5 0x2B stored", rw_regs['h2B*8 +: 8], 8'h22);

      // R5 R6: read-only window and past its end
      i2c_start();
      put("R1 address", 8'h86, 1'b1);
      put("R2 sub ack", 8'h2C, 1'b1); mptr = 8'h2C;
      i2c_start();
      put("R9 read address", 8'h87, 1'b1);
      get("R5 status 0x2C", 1'b1);
      get("R5 status 0x2D", 1'b0);
      i2c_stop();
      i2c_start();
      put("R1 address", 8'h86, 1'b1);
      put("R2 sub ack", 8'h38, 1'b1); mptr = 8'h38;
      i2c_start();
      put("R9 read address", 8'h87, 1'b1);
      get("R5 status 0x38", 1'b1);
      get("R5 status 0x39", 1'b1);
      get("R6 empty 0x3A", 1'b1);
      get("R6 empty 0x3B", 1'b0);
      chk("R8 released", sda_oe, 0);
      i2c_stop();

      // R9: pointer set, STOP, then a separate read
      i2c_start();
      put("R1 address", 8'h86, 1'b1);
      put("R2 sub ack", 8'h05, 1'b1); mptr = 8'h05;
      i2c_stop();
      i2c_start();
      put("R9 read after stop", 8'h87, 1'b1);
      get("R3 read 0x05 default", 1'b1);
      get("R3 read 0x06 default", 1'b0);
      i2c_stop();

      // R4: reset again
      cmp_en = 1'b0;
      rst_n = 1'b0; wq(3);
      model_reset();
      rst_n = 1'b1; wq(3);
      chk("R4 second reset image", (rw_regs === model_flat()), 1);
      cmp_en = 1'b1;
      i2c_start();
      put("R1 address", 8'h86, 1'b1);
      i2c_start();
      put("R4 read address", 8'h87, 1'b1);
      get("R4 pointer reset to 0x00", 1'b0);
      i2c_stop();

      wq(10);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule